// File: doc/BRIEF.md
# Asynchronous AHB Single-Transfer Bridge

This block links an AHB subordinate port running on one clock to an AHB manager port running on a second clock, with no fixed relationship between the two. A selected transfer on the source side has its address phase captured. The source data phase is then stretched with wait states while the request crosses into the destination domain, runs there as a single NONSEQ transfer, and reports back. Read data returns to the source side in the same cycle that its ready output rises again.

Exactly one transfer is in flight at any time. Each crossing uses a toggle request and a toggle acknowledge, and each toggle passes through a two-stage synchronizer. Consecutive transfers therefore each pay the full round trip, and nothing overlaps. Cycles that are idle or unselected, or whose size exceeds the 32-bit data path, are dropped at once and add no wait states. Each side has its own synchronous active-high reset.

Top module: `ahb_async_bridge`

## Requirements
- R1: After both resets, `s_ready` is high and `d_trans` is IDLE (2'b00).
- R2: Once a valid address phase is accepted, `s_ready` is low in the following source cycle. It stays low until the destination transfer has finished. With a source clock N times faster than the destination clock, there are at least N low cycles.
- R3: A forwarded transfer appears on the destination as `d_trans` NONSEQ (2'b10) with `d_burst` SINGLE (3'b000). It carries the source address, direction, size and data-phase write data unchanged.
- R4: A read returns the destination's data-phase read data on `s_rdata` in the cycle `s_ready` returns high.
- R5: Sizes 0 (byte), 1 (halfword) and 2 (word) are forwarded with `d_size` equal to `s_size`. Byte lanes follow the low address bits, little-endian.
- R6: When `s_sel` is 0 or `s_trans` is IDLE (2'b00), nothing is forwarded and `s_ready` stays high.
- R7: When `s_size` is greater than 2, nothing is forwarded and `s_ready` stays high.
- R8: A SEQ (2'b11) source transfer is handled as an independent single transfer and appears on the destination as NONSEQ.
- R9: In back-to-back transfers, each one drops `s_ready` and waits the full crossing. The destination never starts an address phase in the cycle right after an address phase has been accepted.
- R10: While `d_ready` is low, the destination keeps its address phase stable and waits. Read data is captured only in a data-phase cycle with `d_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Source domain clock |
| s_rst | input | 1 | Source synchronous reset, active high |
| s_sel | input | 1 | Source select |
| s_trans | input | 2 | Source transfer type |
| s_addr | input | AW | Source address |
| s_write | input | 1 | Source direction, 1 = write |
| s_size | input | 3 | Source transfer size |
| s_wdata | input | DW | Source write data (data phase) |
| s_rdata | output | DW | Read data back to source |
| s_ready | output | 1 | Source ready output |
| d_clk | input | 1 | Destination domain clock |
| d_rst | input | 1 | Destination synchronous reset, active high |
| d_addr | output | AW | Destination address |
| d_trans | output | 2 | Destination transfer type |
| d_write | output | 1 | Destination direction |
| d_size | output | 3 | Destination size |
| d_burst | output | 3 | Destination burst type, always SINGLE |
| d_wdata | output | DW | Destination write data |
| d_rdata | input | DW | Destination read data |
| d_ready | input | 1 | Destination bus ready |

## Verification
The bench targets the wait-state floor. The source clock runs more than four times faster than the destination clock. A bridge that releases ready early, or on a fixed count, would show fewer low cycles than the ratio demands. Idle, unselected and over-wide cycles are checked at the destination, where a forwarding count shows whether a faulty filter leaked a transfer. That count is read together with `s_ready`, which would show a spurious stall.

The destination model holds `d_ready` low during read data phases and drives a poison word while it does. Early capture of read data would therefore return that poison word. Byte and halfword writes followed by word reads would expose a size that was dropped or altered on the way across. Back-to-back transfers would expose a bridge that skips the handshake for the second transfer.

// File: rtl/ahb_xbr_pkg.sv
package ahb_xbr_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
  localparam logic [2:0] BURST_SINGLE = 3'b000;

  typedef enum logic [1:0] {SRC_IDLE, SRC_DATA, SRC_WAIT} src_st_t;
  typedef enum logic [1:0] {DST_IDLE, DST_ADDR, DST_DATA} dst_st_t;
endpackage

// File: rtl/ahb_xbr_sync.sv
module ahb_xbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ahb_xbr_src.sv
module ahb_xbr_src
  import ahb_xbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic [1:0]    trans,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic [2:0]    size,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready,
  output logic          req_tgl,
  input  logic          ack_sync,
  output logic [AW-1:0] h_addr,
  output logic          h_write,
  output logic [2:0]    h_size,
  output logic [DW-1:0] h_wdata,
  input  logic [DW-1:0] x_rdata
);
  localparam int MAX_SIZE = $clog2(DW / 8);

  src_st_t st;
  logic    take;

  assign take = sel && (trans == TR_NONSEQ || trans == TR_SEQ) &&
                (int'(size) <= MAX_SIZE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SRC_IDLE;
      ready   <= 1'b1;
      req_tgl <= 1'b0;
      rdata   <= '0;
      h_addr  <= '0;
      h_write <= 1'b0;
      h_size  <= '0;
      h_wdata <= '0;
    end else begin
      case (st)
        SRC_IDLE: if (take) begin
          h_addr  <= addr;
          h_write <= write;
          h_size  <= size;
          ready   <= 1'b0;
          st      <= SRC_DATA;
        end
        SRC_DATA: begin
          h_wdata <= wdata;
          req_tgl <= ~req_tgl;
          st      <= SRC_WAIT;
        end
        SRC_WAIT: if (ack_sync == req_tgl) begin
          rdata <= x_rdata;
          ready <= 1'b1;
          st    <= SRC_IDLE;
        end
        default: st <= SRC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ahb_xbr_dst.sv
module ahb_xbr_dst
  import ahb_xbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_sync,
  output logic          ack_tgl,
  input  logic [AW-1:0] h_addr,
  input  logic          h_write,
  input  logic [2:0]    h_size,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] x_rdata,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_trans,
  output logic          m_write,
  output logic [2:0]    m_size,
  output logic [2:0]    m_burst,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ready
);
  dst_st_t st;

  assign m_burst = BURST_SINGLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= DST_IDLE;
      ack_tgl <= 1'b0;
      x_rdata <= '0;
      m_addr  <= '0;
      m_trans <= TR_IDLE;
      m_write <= 1'b0;
      m_size  <= '0;
      m_wdata <= '0;
    end else begin
      case (st)
        DST_IDLE: if (req_sync != ack_tgl) begin
          m_addr  <= h_addr;
          m_write <= h_write;
          m_size  <= h_size;
          m_trans <= TR_NONSEQ;
          st      <= DST_ADDR;
        end
        DST_ADDR: if (m_ready) begin
          m_trans <= TR_IDLE;
          m_wdata <= h_wdata;
          st      <= DST_DATA;
        end
        DST_DATA: if (m_ready) begin
          x_rdata <= m_rdata;
          ack_tgl <= ~ack_tgl;
          st      <= DST_IDLE;
        end
        default: st <= DST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ahb_async_bridge.sv
module ahb_async_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          s_clk,
  input  logic          s_rst,
  input  logic          s_sel,
  input  logic [1:0]    s_trans,
  input  logic [AW-1:0] s_addr,
  input  logic          s_write,
  input  logic [2:0]    s_size,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          s_ready,
  input  logic          d_clk,
  input  logic          d_rst,
  output logic [AW-1:0] d_addr,
  output logic [1:0]    d_trans,
  output logic          d_write,
  output logic [2:0]    d_size,
  output logic [2:0]    d_burst,
  output logic [DW-1:0] d_wdata,
  input  logic [DW-1:0] d_rdata,
  input  logic          d_ready
);
  logic          req_tgl, req_sync, ack_tgl, ack_sync;
  logic [AW-1:0] h_addr;
  logic          h_write;
  logic [2:0]    h_size;
  logic [DW-1:0] h_wdata, x_rdata;

  ahb_xbr_src #(.AW(AW), .DW(DW)) src_i (
    .clk(s_clk), .rst(s_rst), .sel(s_sel), .trans(s_trans), .addr(s_addr),
    .write(s_write), .size(s_size), .wdata(s_wdata), .rdata(s_rdata),
    .ready(s_ready), .req_tgl(req_tgl), .ack_sync(ack_sync),
    .h_addr(h_addr), .h_write(h_write), .h_size(h_size), .h_wdata(h_wdata),
    .x_rdata(x_rdata)
  );

  ahb_xbr_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk(d_clk), .rst(d_rst), .din(req_tgl), .dout(req_sync)
  );

  ahb_xbr_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk(s_clk), .rst(s_rst), .din(ack_tgl), .dout(ack_sync)
  );

  ahb_xbr_dst #(.AW(AW), .DW(DW)) dst_i (
    .clk(d_clk), .rst(d_rst), .req_sync(req_sync), .ack_tgl(ack_tgl),
    .h_addr(h_addr), .h_write(h_write), .h_size(h_size), .h_wdata(h_wdata),
    .x_rdata(x_rdata), .m_addr(d_addr), .m_trans(d_trans), .m_write(d_write),
    .m_size(d_size), .m_burst(d_burst), .m_wdata(d_wdata), .m_rdata(d_rdata),
    .m_ready(d_ready)
  );
endmodule

// File: rtl/ahb_async_bridge_chk.sv
module ahb_async_bridge_chk #(
  parameter int AW = 32
) (
  input logic          s_clk,
  input logic          s_rst,
  input logic          s_sel,
  input logic [1:0]    s_trans,
  input logic [2:0]    s_size,
  input logic          s_ready,
  input logic          d_clk,
  input logic          d_rst,
  input logic [1:0]    d_trans,
  input logic [2:0]    d_burst,
  input logic [AW-1:0] d_addr,
  input logic          d_ready
);
  logic s_act;
  assign s_act = s_sel && s_trans[1];

  // R2: an accepted valid address phase stalls the following data phase
  p_stall_r2: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_ready && s_act && s_size <= 3'd2) |=> !s_ready);

  // R6: idle or unselected cycles never stall
  p_idle_r6: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_ready && !s_act) |=> s_ready);

  // R7: over-wide sizes never stall
  p_wide_r7: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_ready && s_act && s_size > 3'd2) |=> s_ready);

  // R3, R8: destination only issues NONSEQ single transfers
  p_single_r3: assert property (@(posedge d_clk) disable iff (d_rst)
    (d_trans != 2'b00) |-> (d_trans == 2'b10 && d_burst == 3'b000));

  // R10: address phase held while destination stalls
  p_hold_r10: assert property (@(posedge d_clk) disable iff (d_rst)
    (d_trans == 2'b10 && !d_ready) |=> (d_trans == 2'b10 && $stable(d_addr)));

  // R9: no pipelined second address phase
  p_no_overlap_r9: assert property (@(posedge d_clk) disable iff (d_rst)
    (d_trans == 2'b10 && d_ready) |=> (d_trans == 2'b00));
endmodule

bind ahb_async_bridge ahb_async_bridge_chk #(.AW(AW)) chk_i (
  .s_clk(s_clk), .s_rst(s_rst), .s_sel(s_sel), .s_trans(s_trans),
  .s_size(s_size), .s_ready(s_ready), .d_clk(d_clk), .d_rst(d_rst),
  .d_trans(d_trans), .d_burst(d_burst), .d_addr(d_addr), .d_ready(d_ready)
);

// File: tb/ahb_async_bridge_tb_top.sv
`timescale 1ns/1ps
module ahb_async_bridge_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RATIO_MIN = 4;

  logic          s_clk = 0, d_clk = 0;
  logic          s_rst = 1, d_rst = 1;
  logic          s_sel = 0;
  logic [1:0]    s_trans = 0;
  logic [AW-1:0] s_addr = 0;
  logic          s_write = 0;
  logic [2:0]    s_size = 0;
  logic [DW-1:0] s_wdata = 0;
  logic [DW-1:0] s_rdata;
  logic          s_ready;
  logic [AW-1:0] d_addr;
  logic [1:0]    d_trans;
  logic          d_write;
  logic [2:0]    d_size, d_burst;
  logic [DW-1:0] d_wdata;
  logic [DW-1:0] d_rdata = 32'hDEAD_BEEF;
  logic          d_ready = 1;

  always #2.5  s_clk = ~s_clk;
  always #11.5 d_clk = ~d_clk;

  ahb_async_bridge #(.AW(AW), .DW(DW)) dut_i (.*);

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // destination subordinate model
  logic [31:0] mem [0:15];
  logic        dph = 0, dph_wr = 0;
  logic [31:0] dph_addr = 0;
  logic [2:0]  dph_size = 0;
  int          stall_left = 0, slave_wait = 0, fwd_cnt = 0;
  logic [31:0] l_addr = 0, l_wdata = 0;
  logic        l_write = 0;
  logic [2:0]  l_size = 0, l_burst = 0;
  logic [1:0]  l_trans = 0;

  initial for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i;

  always @(posedge d_clk) begin
    if (dph && d_ready) begin
      dph <= 0;
      l_wdata <= d_wdata;
      if (dph_wr) begin
        case (dph_size)
          3'd0: mem[dph_addr[5:2]][dph_addr[1:0]*8 +: 8] <= d_wdata[dph_addr[1:0]*8 +: 8];
          3'd1: mem[dph_addr[5:2]][dph_addr[1]*16 +: 16] <= d_wdata[dph_addr[1]*16 +: 16];
          default: mem[dph_addr[5:2]] <= d_wdata;
        endcase
      end
    end else if (dph && !d_ready) begin
      stall_left <= stall_left - 1;
    end
    if (d_trans != 2'b00 && d_ready) begin
      dph <= 1; dph_wr <= d_write; dph_addr <= d_addr; dph_size <= d_size;
      stall_left <= slave_wait;
      l_addr <= d_addr; l_write <= d_write; l_size <= d_size;
      l_burst <= d_burst; l_trans <= d_trans;
      fwd_cnt <= fwd_cnt + 1;
    end
  end

  always @(negedge d_clk) begin
    d_ready = !(dph && stall_left != 0);
    d_rdata = (dph && d_ready) ? mem[dph_addr[5:2]] : 32'hDEAD_BEEF;
  end

  // source manager: one address phase, then the data phase until ready
  task automatic xfer(input logic sel, input logic [1:0] tr, input logic wr,
                      input logic [2:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output int waits, output bit low_first);
    @(negedge s_clk);
    s_sel = sel; s_trans = tr; s_write = wr; s_size = sz; s_addr = a;
    @(negedge s_clk);
    s_sel = 0; s_trans = 2'b00; s_wdata = wd;
    low_first = !s_ready;
    waits = 0;
    while (!s_ready && waits < 20000) begin
      waits++;
      @(negedge s_clk);
    end
    rd = s_rdata;
  endtask

  task automatic t_reset();
    chk(s_ready == 1'b1, "R1", "s_ready after reset", {31'd0, s_ready}, 1);
    chk(d_trans == 2'b00, "R1", "d_trans after reset", {30'd0, d_trans}, 0);
  endtask

  task automatic t_word_write();
    logic [31:0] rd; int w; bit lf; int c0;
    c0 = fwd_cnt;
    xfer(1, 2'b10, 1, 3'd2, 32'h10, 32'hA5A5_1234, rd, w, lf);
    chk(lf, "R2", "ready low in data phase", {31'd0, lf}, 1);
    chk(w >= RATIO_MIN, "R2", "wait count floor", w, RATIO_MIN);
    chk(fwd_cnt == c0 + 1, "R3", "forward count", fwd_cnt, c0 + 1);
    chk(l_addr == 32'h10, "R3", "dest address", l_addr, 32'h10);
    chk(l_write == 1, "R3", "dest direction", {31'd0, l_write}, 1);
    chk(l_burst == 3'b000, "R3", "dest burst", {29'd0, l_burst}, 0);
    chk(l_wdata == 32'hA5A5_1234, "R3", "dest wdata", l_wdata, 32'hA5A5_1234);
  endtask

  task automatic t_read_stalled();
    logic [31:0] rd; int w; bit lf;
    slave_wait = 2;
    xfer(1, 2'b10, 0, 3'd2, 32'h10, 32'h0, rd, w, lf);
    chk(rd == 32'hA5A5_1234, "R4", "read data", rd, 32'hA5A5_1234);
    chk(rd != 32'hDEAD_BEEF, "R10", "no capture while stalled", rd, 32'hA5A5_1234);
    chk(l_write == 0, "R3", "read direction", {31'd0, l_write}, 0);
    slave_wait = 0;
  endtask

  task automatic t_sizes();
    logic [31:0] rd; int w; bit lf;
    xfer(1, 2'b10, 1, 3'd0, 32'h13, 32'h7700_0000, rd, w, lf);
    chk(l_size == 3'd0, "R5", "byte size forwarded", {29'd0, l_size}, 0);
    xfer(1, 2'b10, 0, 3'd2, 32'h10, 32'h0, rd, w, lf);
    chk(rd == 32'h77A5_1234, "R5", "byte lane 3 merged", rd, 32'h77A5_1234);
    xfer(1, 2'b10, 1, 3'd1, 32'h14, 32'h0000_BEEF, rd, w, lf);
    chk(l_size == 3'd1, "R5", "halfword size forwarded", {29'd0, l_size}, 1);
    chk(w >= RATIO_MIN, "R5", "halfword still waits", w, RATIO_MIN);
    xfer(1, 2'b10, 0, 3'd2, 32'h14, 32'h0, rd, w, lf);
    chk(rd == 32'h1000_BEEF, "R5", "halfword lane 0 merged", rd, 32'h1000_BEEF);
  endtask

  task automatic t_ignored();
    logic [31:0] rd; int w; bit lf; int c0;
    c0 = fwd_cnt;
    xfer(1, 2'b00, 1, 3'd2, 32'h18, 32'h1111_1111, rd, w, lf);
    chk(!lf && w == 0, "R6", "idle cycle stalled", w, 0);
    xfer(0, 2'b10, 1, 3'd2, 32'h18, 32'h2222_2222, rd, w, lf);
    chk(!lf && w == 0, "R6", "unselected cycle stalled", w, 0);
    xfer(1, 2'b10, 1, 3'd3, 32'h18, 32'h3333_3333, rd, w, lf);
    chk(!lf && w == 0, "R7", "wide cycle stalled", w, 0);
    repeat (60) @(negedge s_clk);
    chk(fwd_cnt == c0, "R6", "ignored cycles forwarded", fwd_cnt, c0);
    xfer(1, 2'b10, 0, 3'd2, 32'h18, 32'h0, rd, w, lf);
    chk(rd == 32'h1000_0006, "R7", "memory untouched by ignored", rd, 32'h1000_0006);
  endtask

  task automatic t_seq();
    logic [31:0] rd; int w; bit lf; int c0;
    c0 = fwd_cnt;
    xfer(1, 2'b11, 1, 3'd2, 32'h20, 32'hC0DE_0008, rd, w, lf);
    chk(lf, "R8", "SEQ stalls", {31'd0, lf}, 1);
    chk(fwd_cnt == c0 + 1, "R8", "SEQ forwarded", fwd_cnt, c0 + 1);
    chk(l_trans == 2'b10, "R8", "SEQ sent as NONSEQ", {30'd0, l_trans}, 2);
  endtask

  task automatic t_back_to_back();
    logic [31:0] rd; int w1, w2; bit l1, l2; int c0;
    c0 = fwd_cnt;
    xfer(1, 2'b10, 1, 3'd2, 32'h24, 32'h0000_0A0A, rd, w1, l1);
    xfer(1, 2'b10, 1, 3'd2, 32'h28, 32'h0000_0B0B, rd, w2, l2);
    chk(l1 && w1 >= RATIO_MIN, "R9", "first transfer waits", w1, RATIO_MIN);
    chk(l2 && w2 >= RATIO_MIN, "R9", "second transfer waits", w2, RATIO_MIN);
    chk(fwd_cnt == c0 + 2, "R9", "both forwarded", fwd_cnt, c0 + 2);
    xfer(1, 2'b10, 0, 3'd2, 32'h28, 32'h0, rd, w1, l1);
    chk(rd == 32'h0000_0B0B, "R9", "second write landed", rd, 32'h0000_0B0B);
  endtask

  initial begin
    repeat (4) @(posedge d_clk);
    @(negedge s_clk); s_rst = 0;
    @(negedge d_clk); d_rst = 0;
    repeat (3) @(negedge s_clk);
    t_reset();
    t_word_write();
    t_read_stalled();
    t_sizes();
    t_ignored();
    t_seq();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule